// File: doc/BRIEF.md
# Gate-Sequenced Reversible Ripple-Carry Adder

This block adds two unsigned n-bit operands by walking, one gate per clock, through a fixed schedule of reversible gates. Only two gate kinds are used: a controlled-controlled-NOT, which flips a target bit when both control bits are 1, and a controlled-NOT, which flips a target bit when one control bit is 1. The gates act on a flat state of 3n+1 bits. That state holds n+1 carry ancillas, which start at zero, one operand that must come out unchanged, and a second operand that is overwritten by the sum. Every bit is a classical basis value; no amplitudes are modelled.

A run is launched by a one-cycle `start` while the block is idle. The first operand and the second operand are captured into the state and all ancillas are cleared. The sequencer then runs three passes. The forward pass applies a three-gate carry macro per bit, from the lowest bit upward. A three-gate top-bit step follows. The backward pass, from bit n-2 down to bit 0, applies a five-gate pair made of the inverse carry macro and a sum macro; this restores the lower carry ancillas to zero. When the run ends, `done` pulses and `sumOut` presents the (n+1)-bit result, with the top carry ancilla as its MSB. `ancillaClean` confirms that the reversible bookkeeping held: the lower ancillas are all zero and the first operand matches its captured value.

Top module: `rev_ripple_adder`

## Requirements
- R1: A start accepted while idle (start high with busy low) makes busy high from the next cycle for exactly 8n-2 cycles, one per gate (30 for n = 4).
- R2: done is high for exactly one cycle, which is the first cycle with busy low after a run.
- R3: While done is high, sumOut[n-1:0] equals (A + B) mod 2^n and sumOut[n] is 1 exactly when A + B >= 2^n; for n = 4, 9 + 6 gives 15 and 15 + 15 gives 30.
- R4: While done is high, ancillaClean is 1: carry ancillas 0..n-1 are zero and the first operand in the state equals the value captured at start.
- R5: A start pulse while busy is high is ignored: the running result and the run length do not change.
- R6: opA and opB are sampled only in the cycle of an accepted start; changing them later during the run has no effect on the result.
- R7: While the block is idle and start is low, sumOut does not change.
- R8: After reset, busy and done are 0, sumOut is 0 and ancillaClean is 1.
- R9: A start given in the same cycle as done is accepted, so runs can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run; accepted only while busy is low |
| opA | input | W | First operand, kept unchanged by the run |
| opB | input | W | Second operand, replaced in the state by the sum |
| busy | output | 1 | High while gates are being applied |
| done | output | 1 | One-cycle pulse after the last gate |
| sumOut | output | W+1 | Result: top carry ancilla as MSB, then the sum bits |
| ancillaClean | output | 1 | Lower ancillas are zero and the first operand is intact |

## Verification
Completion and acceptance of a new run can land in the same cycle. The bench drives start in exactly the cycle in which done is seen, for every one of the 256 operand pairs. Each result is judged from the scoreboard entry of its own run, together with the latency and the clean flag. A second collision is a start pulse and changed operands arriving in the middle of a run. This is judged by demanding the original sum and an unchanged 31-cycle start-to-done distance.

// File: rtl/rev_adder_pkg.sv
package rev_adder_pkg;

  // Width of a gate operand index carried in the command struct.
  localparam int GIDX_W = 12;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FWD,
    PH_MSB,
    PH_BWD
  } phase_t;

  // Strobes and operand indices sent from the sequencer to the datapath.
  typedef struct packed {
    logic              load;     // capture operands, clear ancillas
    logic              fire;     // apply one gate this cycle
    logic              toffoli;  // 1: two controls, 0: one control
    logic              last;     // final gate of the schedule
    logic [GIDX_W-1:0] ctlA;
    logic [GIDX_W-1:0] ctlB;
    logic [GIDX_W-1:0] tgt;
  } gateCmd_t;

endpackage

// File: rtl/addseq_ctrl.sv
module addseq_ctrl
  import rev_adder_pkg::*;
#(
  parameter int W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output logic     busy,
  output logic     done,
  output gateCmd_t cmd
);

  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] POS_TOP  = PW'(W - 1);
  localparam logic [PW-1:0] POS_BACK = PW'((W > 1) ? (W - 2) : 0);

  phase_t        phase;
  logic [PW-1:0] pos;
  logic [2:0]    step;
  logic          doneQ;
  int unsigned   p;

  // State layout: carries at 0..W, first operand at W+1..2W, second at 2W+1..3W.
  function automatic logic [GIDX_W-1:0] cIx(input int unsigned i);
    return GIDX_W'(i);
  endfunction

  function automatic logic [GIDX_W-1:0] aIx(input int unsigned i);
    return GIDX_W'(W + 1 + i);
  endfunction

  function automatic logic [GIDX_W-1:0] bIx(input int unsigned i);
    return GIDX_W'(2 * W + 1 + i);
  endfunction

  assign p = 32'(pos);

  always_comb begin
    cmd      = '0;
    cmd.load = (phase == PH_IDLE) && start;
    unique case (phase)
      PH_FWD: begin
        cmd.fire = 1'b1;
        unique case (step)
          3'd0: begin
            cmd.toffoli = 1'b1;
            cmd.ctlA    = aIx(p);
            cmd.ctlB    = bIx(p);
            cmd.tgt     = cIx(p + 1);
          end
          3'd1: begin
            cmd.ctlA = aIx(p);
            cmd.ctlB = aIx(p);
            cmd.tgt  = bIx(p);
          end
          default: begin
            cmd.toffoli = 1'b1;
            cmd.ctlA    = cIx(p);
            cmd.ctlB    = bIx(p);
            cmd.tgt     = cIx(p + 1);
          end
        endcase
      end
      PH_MSB: begin
        cmd.fire = 1'b1;
        cmd.tgt  = bIx(W - 1);
        if (step == 3'd2) begin
          cmd.ctlA = cIx(W - 1);
          cmd.ctlB = cIx(W - 1);
          cmd.last = (W == 1);
        end else begin
          cmd.ctlA = aIx(W - 1);
          cmd.ctlB = aIx(W - 1);
        end
      end
      PH_BWD: begin
        cmd.fire = 1'b1;
        unique case (step)
          3'd0: begin
            cmd.toffoli = 1'b1;
            cmd.ctlA    = cIx(p);
            cmd.ctlB    = bIx(p);
            cmd.tgt     = cIx(p + 1);
          end
          3'd2: begin
            cmd.toffoli = 1'b1;
            cmd.ctlA    = aIx(p);
            cmd.ctlB    = bIx(p);
            cmd.tgt     = cIx(p + 1);
          end
          3'd4: begin
            cmd.ctlA = cIx(p);
            cmd.ctlB = cIx(p);
            cmd.tgt  = bIx(p);
            cmd.last = (pos == '0);
          end
          default: begin
            cmd.ctlA = aIx(p);
            cmd.ctlB = aIx(p);
            cmd.tgt  = bIx(p);
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      pos   <= '0;
      step  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= cmd.last;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_FWD;
            pos   <= '0;
            step  <= '0;
          end
        end
        PH_FWD: begin
          if (step == 3'd2) begin
            step <= '0;
            if (pos == POS_TOP) phase <= PH_MSB;
            else                pos   <= pos + 1'b1;
          end else begin
            step <= step + 3'd1;
          end
        end
        PH_MSB: begin
          if (step == 3'd2) begin
            step <= '0;
            if (W == 1) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_BWD;
              pos   <= POS_BACK;
            end
          end else begin
            step <= step + 3'd1;
          end
        end
        default: begin
          if (step == 3'd4) begin
            step <= '0;
            if (pos == '0) phase <= PH_IDLE;
            else           pos   <= pos - 1'b1;
          end else begin
            step <= step + 3'd1;
          end
        end
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/addseq_dp.sv
module addseq_dp
  import rev_adder_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  gateCmd_t     cmd,
  output logic [W:0]   sumOut,
  output logic         ancillaClean
);

  localparam int SB = 3 * W + 1;
  localparam int IW = $clog2(SB);

  logic [SB-1:0] st;
  logic [W-1:0]  aHeld;
  logic [IW-1:0] tIdx, aIdx, bIdx;
  logic          ctlBit;
  logic          unusedIdxBits;

  assign tIdx = cmd.tgt[IW-1:0];
  assign aIdx = cmd.ctlA[IW-1:0];
  assign bIdx = cmd.ctlB[IW-1:0];
  assign unusedIdxBits = ^{cmd.tgt[GIDX_W-1:IW], cmd.ctlA[GIDX_W-1:IW],
                           cmd.ctlB[GIDX_W-1:IW], cmd.last};

  // Flip condition of the current gate.
  assign ctlBit = st[aIdx] & (cmd.toffoli ? st[bIdx] : 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= '0;
      aHeld <= '0;
    end else if (cmd.load) begin
      st    <= {opB, opA, {(W + 1){1'b0}}};
      aHeld <= opA;
    end else if (cmd.fire) begin
      st[tIdx] <= st[tIdx] ^ ctlBit;
    end
  end

  assign sumOut       = {st[W], st[SB-1:2*W+1]};
  assign ancillaClean = (st[W-1:0] == '0) && (st[2*W:W+1] == aHeld);

endmodule

// File: rtl/rev_ripple_adder.sv
module rev_ripple_adder
  import rev_adder_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W:0]   sumOut,
  output logic         ancillaClean
);

  gateCmd_t cmd;

  addseq_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cmd   (cmd)
  );

  addseq_dp #(.W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .opA          (opA),
    .opB          (opB),
    .cmd          (cmd),
    .sumOut       (sumOut),
    .ancillaClean (ancillaClean)
  );

endmodule

// File: rtl/rev_ripple_adder_chk.sv
module rev_ripple_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         busy,
  input logic         done,
  input logic [W:0]   sumOut,
  input logic         ancillaClean
);

  localparam int GATES = 8 * W - 2;

  int unsigned busyCnt;
  logic [W:0]  expSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= 0;
      expSum  <= '0;
    end else begin
      busyCnt <= busy ? busyCnt + 1 : 0;
      if (start && !busy) expSum <= (W + 1)'(opA) + (W + 1)'(opB);
    end
  end

  // R1: run length is one cycle per gate
  a_r1_run_length: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyCnt == GATES);

  // R1: accepted start raises busy in the next cycle
  a_r1_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2: done is a single-cycle pulse that follows the end of busy
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3 / R6: result matches operands sampled at the accepted start
  a_r3_sum: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sumOut == expSum);

  // R4: ancillas restored and first operand intact
  a_r4_clean: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ancillaClean);

  // R7: result held while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(sumOut));

endmodule

bind rev_ripple_adder rev_ripple_adder_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .opA          (opA),
  .opB          (opB),
  .busy         (busy),
  .done         (done),
  .sumOut       (sumOut),
  .ancillaClean (ancillaClean)
);

// File: tb/rev_ripple_adder_bench.sv
`timescale 1ns/1ps
module rev_ripple_adder_bench;

  localparam int W   = 4;
  localparam int LAT = 8 * W - 1;  // negedge of start to negedge of done

  typedef struct {
    logic [W:0] sum;
    longint     startCyc;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [W-1:0] opA, opB;
  logic         busy, done, ancillaClean;
  logic [W:0]   sumOut;

  int     checks   = 0;
  int     failures = 0;
  longint cycleCnt = 0;
  item_t  q[$];
  logic   prevDone = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  rev_ripple_adder #(.W(W)) u_rev_ripple_adder (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .opA          (opA),
    .opB          (opB),
    .busy         (busy),
    .done         (done),
    .sumOut       (sumOut),
    .ancillaClean (ancillaClean)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Driver: waits until idle (or the done cycle, R9), queues the expectation, starts.
  task automatic runOp(input int a, input int b, input bit perturb);
    item_t it;
    do @(negedge clk); while (busy);
    it.sum      = (W + 1)'(a + b);
    it.startCyc = cycleCnt;
    q.push_back(it);
    opA   = W'(a);
    opB   = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (perturb) begin
      // R5 and R6: stray start and new operands in mid-run
      repeat (4) @(negedge clk);
      opA   = ~W'(a);
      opB   = W'(b + 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      opA = W'(a + 7);
    end
  endtask

  // Monitor: scoreboard pop and compare at every done.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done) begin
        check(!prevDone, "R2", "done longer than one cycle", 1, 0);
        check(!busy, "R2", "busy during done", longint'(busy), 0);
        if (q.size() == 0) begin
          check(1'b0, "R2", "done without queued run", 1, 0);
        end else begin
          it = q.pop_front();
          check(cycleCnt - it.startCyc == LAT, "R1", "start-to-done cycles",
                cycleCnt - it.startCyc, LAT);
          check(sumOut == it.sum, "R3", "sum with carry-out",
                longint'(sumOut), longint'(it.sum));
          check(ancillaClean, "R4", "ancillaClean at done",
                longint'(ancillaClean), 1);
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finishRun();
  end

  initial begin
    logic [W:0] held;
    rstN  = 1'b0;
    start = 1'b0;
    opA   = '0;
    opB   = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(!busy, "R8", "busy after reset", longint'(busy), 0);
    check(!done, "R8", "done after reset", longint'(done), 0);
    check(sumOut == '0, "R8", "sumOut after reset", longint'(sumOut), 0);
    check(ancillaClean, "R8", "ancillaClean after reset", longint'(ancillaClean), 1);

    // R3 directed: no carry, full carry, zero, ripple through all bits
    runOp(9, 6, 1'b0);
    runOp(15, 15, 1'b0);
    runOp(0, 0, 1'b0);
    runOp(15, 1, 1'b0);
    runOp(8, 8, 1'b0);
    // R5 / R6: disturbed run must still yield 5 + 10
    runOp(5, 10, 1'b1);
    // R9: every pair, each started in the done cycle of the previous run
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        runOp(a, b, 1'b0);
      end
    end
    while (q.size() != 0 || busy) @(negedge clk);

    // R7: idle result is held while operands change
    @(negedge clk);
    held = sumOut;
    opA  = 4'd3;
    opB  = 4'd9;
    repeat (5) @(negedge clk);
    check(sumOut == held, "R7", "sumOut held while idle",
          longint'(sumOut), longint'(held));
    check(held == 5'd30, "R7", "last run result kept", longint'(held), 30);
    finishRun();
  end

endmodule